// File: doc/BRIEF.md
# Character-to-Word Input Packer

This block collects 6-bit characters, each arriving with one odd-parity bit, from a peripheral stream and builds 24-bit words from them. A program-loaded setting chooses how many characters make up one word, from one to four. Each finished word is placed in a one-entry output register, which a consumer drains over a valid/ready handshake. An end-of-record pulse closes the current record. A partly built word is then left-justified, with zeros filling its low character slots, and it stays readable on a residual-word port.

Characters enter at the low end of the assembly word. Each new character pushes the earlier characters up by one 6-bit slot. A word shorter than four characters therefore appears right-justified, with zeros above it.

Every accepted character is parity-checked. Any mismatch sets a sticky error flag. Only the explicit clear input resets this flag; the end of a record does not.

Back-pressure rules:
- A character moves on a cycle where `in_valid` and `in_ready` are both high.
- A word moves on a cycle where `out_valid` and `out_ready` are both high.
- `out_word` holds steady while `out_valid` is high and `out_ready` is low.
- `in_ready` drops only when the next character would complete a word while the output register is full and is not being drained in that cycle, or while `rec_end` is high.
- `in_ready` depends combinationally on `out_ready` and `rec_end`.

Top module: `char_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `asm_word` is 0, `err_flag` is 0, `in_ready` is 1 with idle inputs, and the word length is four characters.
- R2: With a word length of four, the characters c1..c4 are delivered as `out_word = {c1,c2,c3,c4}`, where c1 is in bits 23:18 and c4 is in bits 5:0. The word is loaded on the edge that accepts c4.
- R3: With a word length of k (1 to 3), the delivered word holds its k characters in the low 6k bits, first character highest, with zeros in all bits above.
- R4: A character accepted after a word completes begins a new word. The assembly register `asm_word` is zero right after a word is delivered, and it stays zero when `rec_end` then arrives.
- R5: While a word is in progress, `asm_word` shows its characters right-justified. When `rec_end` arrives with j characters held (0 < j < k), `asm_word` becomes those characters left-justified, with bits 23:18 holding the first, zeros below them, and the count returns to zero.
- R6: Parity is odd: a character is correct when the XOR of `in_char` and `in_par` is 1. An accepted character with even parity sets `err_flag` on the next edge.
- R7: `err_flag` is sticky. Only `err_clr` clears it, and `rec_end` leaves it unchanged. A new error in the same cycle as `err_clr` wins.
- R8: When a character would complete a word while `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. No word is lost or overwritten.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_word` is stable. `out_valid` falls after a transfer with no new word loaded.
- R10: `cfg_wr` loads the word length `cfg_cpw + 1` (`cfg_cpw` = 0..3) only in a cycle with no character held and none accepted. Otherwise it is ignored.
- R11: While `rec_end` is 1, `in_ready` is 0 and no character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the word-length setting |
| cfg_cpw | input | 2 | Characters per word minus one |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken |
| in_char | input | 6 | Character data |
| in_par | input | 1 | Odd parity bit of the character |
| rec_end | input | 1 | End of record / disconnect pulse |
| err_clr | input | 1 | Clears the sticky parity error |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 24 | Delivered word |
| asm_word | output | 24 | Assembly / residual word |
| err_flag | output | 1 | Sticky parity error |

## Verification
Directed runs cover full four-character words and two-character words, which separate the entry order from the right-justified zero fill. A record that ends after two characters of a three-character word checks the left-justification shift. An end that falls exactly on a word boundary checks that the residual stays zero. A length change issued mid-word shows whether the setting is wrongly applied at once, and a stalled consumer shows whether a completing word can overrun the output register. A long stretch of mixed random traffic then follows, with:
- random stalls;
- parity faults;
- record ends;
- error clears;
- length changes.

A behavioural queue model checks this traffic on every cycle. It catches ordering, priority and counting slips that no single directed case would reach.

// File: rtl/char_packer_pkg.sv
package char_packer_pkg;
  parameter int CHAR_W    = 6;
  parameter int MAX_CHARS = 4;
  localparam int WORD_W   = CHAR_W * MAX_CHARS;
  localparam int CNT_W    = $clog2(MAX_CHARS);
  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/char_packer_asm.sv
module char_packer_asm
  import char_packer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  char_t ch,
  input  logic  flush,
  input  cnt_t  last,
  output word_t acc_q,
  output cnt_t  cnt_q,
  output logic  done,
  output word_t done_word
);
  word_t shifted;
  word_t justified;

  // New character enters the low slot; earlier ones move up one slot.
  assign shifted   = (cnt_q == '0) ? word_t'(ch)
                                   : {acc_q[WORD_W-CHAR_W-1:0], ch};
  assign done      = take && (cnt_q == last);
  assign done_word = shifted;

  // Left-justify a partial word: slide it up by the number of empty slots.
  always_comb begin
    justified = acc_q;
    for (int k = 1; k < MAX_CHARS; k++) begin
      if (cnt_q == cnt_t'(k)) justified = acc_q << (CHAR_W * (MAX_CHARS - k));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (done) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= shifted;
        cnt_q <= cnt_q + cnt_t'(1);
      end
    end else if (flush && (cnt_q != '0)) begin
      acc_q <= justified;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/char_packer_parity.sv
module char_packer_parity
  import char_packer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  char_t ch,
  input  logic  par,
  input  logic  clr,
  output logic  err_q
);
  logic bad;
  assign bad = take && !(^{ch, par});

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (err_q && !clr) || bad;
  end
endmodule

// File: rtl/char_packer_outreg.sv
module char_packer_outreg
  import char_packer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t din,
  input  logic  ready,
  output logic  valid_q,
  output word_t data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= din;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/char_packer.sv
module char_packer
  import char_packer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_cpw,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_par,
  input  logic              rec_end,
  input  logic              err_clr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [WORD_W-1:0] asm_word,
  output logic              err_flag
);
  cnt_t  last_q;
  cnt_t  cnt_q;
  logic  take;
  logic  done;
  word_t done_word;

  assign in_ready = !rec_end && !((cnt_q == last_q) && out_valid && !out_ready);
  assign take     = in_valid && in_ready;

  // Word-length setting: only between words, never while a character lands.
  always_ff @(posedge clk) begin
    if (!rst_n)                                last_q <= '1;
    else if (cfg_wr && (cnt_q == '0) && !take) last_q <= cfg_cpw;
  end

  char_packer_asm u_asm (
    .clk(clk), .rst_n(rst_n), .take(take), .ch(in_char), .flush(rec_end),
    .last(last_q), .acc_q(asm_word), .cnt_q(cnt_q), .done(done),
    .done_word(done_word)
  );

  char_packer_parity u_par (
    .clk(clk), .rst_n(rst_n), .take(take), .ch(in_char), .par(in_par),
    .clr(err_clr), .err_q(err_flag)
  );

  char_packer_outreg u_out (
    .clk(clk), .rst_n(rst_n), .load(done), .din(done_word), .ready(out_ready),
    .valid_q(out_valid), .data_q(out_word)
  );
endmodule

// File: rtl/char_packer_chk.sv
module char_packer_chk
  import char_packer_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        rec_end,
  input logic        err_clr,
  input logic        out_valid,
  input logic        out_ready,
  input word_t       out_word,
  input word_t       asm_word,
  input logic        err_flag,
  input cnt_t        cnt_q,
  input cnt_t        last_q
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  assert_recend_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_end |-> !in_ready);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (cnt_q == last_q) |=> out_valid && (cnt_q == '0));

  assert_clear_after_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> asm_word == '0);

  assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_q);
endmodule

bind char_packer char_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rec_end(rec_end), .err_clr(err_clr), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .asm_word(asm_word),
  .err_flag(err_flag), .cnt_q(cnt_q), .last_q(last_q)
);

// File: tb/char_packer_bench.sv
`timescale 1ns/1ps
module char_packer_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_wr = 0;
  logic [1:0] cfg_cpw = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [5:0] in_char = 0;
  logic in_par = 0;
  logic rec_end = 0;
  logic err_clr = 0;
  logic out_valid;
  logic out_ready = 1;
  logic [23:0] out_word;
  logic [23:0] asm_word;
  logic err_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  char_packer u_char_packer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cpw(cfg_cpw),
    .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
    .in_par(in_par), .rec_end(rec_end), .err_clr(err_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .asm_word(asm_word), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [5:0] q[$];
  int n = 4;
  logic [23:0] m_asm = 0, m_ow = 0;
  bit m_ov = 0, m_err = 0;
  bit rdy, tk, bad, ld;
  logic [23:0] w;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); n = 4; m_asm = 0; m_ow = 0; m_ov = 0; m_err = 0;
    end else begin
      rdy = !rec_end && !((q.size() == n - 1) && m_ov && !out_ready);
      tk  = in_valid && rdy;
      bad = tk && ((^{in_char, in_par}) == 1'b0);
      m_err = (m_err && !err_clr) || bad;
      ld = 0;
      if (cfg_wr && q.size() == 0 && !tk) n = int'(cfg_cpw) + 1;
      if (tk) begin
        q.push_back(in_char);
        w = 0;
        foreach (q[i]) w = {w[17:0], q[i]};
        if (q.size() == n) begin
          ld = 1; m_ow = w; m_asm = 0; q.delete();
        end else m_asm = w;
      end else if (rec_end && q.size() > 0) begin
        w = 0;
        foreach (q[i]) w = {w[17:0], q[i]};
        m_asm = w << (6 * (4 - q.size()));
        q.delete();
      end
      if (ld) m_ov = 1;
      else if (out_ready) m_ov = 0;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R9", {23'd0, out_valid}, {23'd0, m_ov});
      if (m_ov) chk("R2", out_word, m_ow);
      chk("R5", asm_word, m_asm);
      chk("R6", {23'd0, err_flag}, {23'd0, m_err});
      chk("R8", {23'd0, in_ready},
          {23'd0, !rec_end && !((q.size() == n - 1) && m_ov && !out_ready)});
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send(input logic [5:0] c, input bit good);
    in_valid = 1; in_char = c; in_par = good ? ~^c : ^c;
    #1;
    while (!in_ready) begin step(); #1; end
    step();
    in_valid = 0;
  endtask

  task automatic cfg(input logic [1:0] v);
    cfg_wr = 1; cfg_cpw = v; step(); cfg_wr = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R8 watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", {23'd0, out_valid}, 24'd0);
    chk("R1", asm_word, 24'd0);
    chk("R1", {23'd0, err_flag}, 24'd0);
    chk("R1", {23'd0, in_ready}, 24'd1);
    @(negedge clk);

    // R1/R2: default length is four
    send(6'd1, 1); send(6'd2, 1); send(6'd3, 1); send(6'd4, 1);
    chk("R2", out_word, 24'h0420C4);
    chk("R4", asm_word, 24'd0);
    rec_end = 1; step(); rec_end = 0;
    chk("R4", asm_word, 24'd0);

    // R3: two characters per word
    cfg(2'd1);
    send(6'd5, 1); send(6'd6, 1);
    chk("R3", out_word, 24'h000146);
    send(6'd7, 1);
    chk("R4", asm_word, 24'h000007);

    // R5: partial record, three per word
    rec_end = 1; step(); rec_end = 0;
    cfg(2'd2);
    send(6'd7, 1); send(6'd8, 1);
    rec_end = 1; in_valid = 1; in_char = 6'd9; in_par = ~^6'd9;
    #1;
    chk("R11", {23'd0, in_ready}, 24'd0);
    step(); rec_end = 0; in_valid = 0;
    chk("R5", asm_word, 24'h1C8000);

    // R10: length change mid-word ignored
    cfg(2'd3);
    send(6'd1, 1);
    cfg(2'd0);
    send(6'd2, 1);
    chk("R10", {23'd0, out_valid}, 24'd0);
    send(6'd3, 1); send(6'd4, 1);
    chk("R10", out_word, 24'h0420C4);

    // R6/R7: parity error is sticky
    send(6'd11, 0);
    chk("R6", {23'd0, err_flag}, 24'd1);
    rec_end = 1; step(); rec_end = 0;
    chk("R7", {23'd0, err_flag}, 24'd1);
    err_clr = 1; step(); err_clr = 0;
    chk("R7", {23'd0, err_flag}, 24'd0);

    // R8: stalled consumer
    cfg(2'd0);
    out_ready = 0;
    send(6'd9, 1);
    chk("R8", out_word, 24'h000009);
    in_valid = 1; in_char = 6'd10; in_par = ~^6'd10;
    #1;
    chk("R8", {23'd0, in_ready}, 24'd0);
    step();
    chk("R9", out_word, 24'h000009);
    out_ready = 1;
    #1;
    chk("R8", {23'd0, in_ready}, 24'd1);
    step(); in_valid = 0;
    chk("R8", out_word, 24'h00000A);
    step();

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      in_valid  = ($urandom % 3) != 0;
      in_char   = 6'($urandom);
      in_par    = (($urandom % 12) == 0) ? ^in_char : ~^in_char;
      out_ready = ($urandom % 4) != 0;
      rec_end   = ($urandom % 25) == 0;
      err_clr   = ($urandom % 30) == 0;
      cfg_wr    = ($urandom % 8) == 0;
      cfg_cpw   = 2'($urandom);
      step();
    end
    in_valid = 0; rec_end = 0; err_clr = 0; cfg_wr = 0; out_ready = 1;
    step(); step();
    finish_run();
  end
endmodule